// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that accepts a read or a write on every active clock edge, with no idle cycle needed when the bus direction changes. The address and the command are registered on one edge. A read then drives its word during the next cycle, straight from the array without an output register. A write takes its data from the bus on the next active edge, under the byte enables that were registered with the address.

A clock-enable input can freeze the whole pipeline, including a read word already on the bus. Three chip-select inputs gate the load cycles. An advance input repeats the last operation at the next address inside an aligned four-word block. The bidirectional data bus is split into a data input, a data output and a drive-enable output.

Top module: `ft_sram`

## Requirements
- R1: After reset `data_oe_o` is low and no read result is pending.
- R2: On an active edge (`cke_ni` low) with `adv_ld_i` low, the chip selected and `rd_wr_i` high (1 = read, 0 = write), the word at `addr_i` is driven on `data_o` with `data_oe_o` high during the next cycle, provided `oe_ni` is low. A new address may be loaded on that same edge, so back-to-back reads give one word per cycle.
- R3: A write loaded on an active edge takes `data_i` on the following active edge. Lane i (bits [8i+7:8i]) is written only if bit i of `bw_ni`, sampled with the address, is low.
- R4: An edge with `cke_ni` high is ignored: no address, command, select, byte enable or data is captured, and the driven read word and `data_oe_o` stay unchanged for any number of such edges.
- R5: The chip is selected only when `cs0_ni` = 0, `cs1_ni` = 0 and `cs_i` = 1. Any other combination on a load edge deselects the chip, and no read is started.
- R6: A deselect edge still completes a write pending from the previous load. The bus is not driven in the following cycle.
- R7: `data_oe_o` is low whenever `oe_ni` is high. When `data_oe_o` is low, `data_o` is all zeros.
- R8: Reads and writes may alternate on consecutive active edges with no idle cycle, and each returns or stores the correct word.
- R9: On an active edge with `adv_ld_i` high, the previous operation type and select state are repeated at the previous address with its two low bits incremented modulo 4. The upper address bits are unchanged, and `bw_ni` is sampled anew.
- R10: A read of an address loaded on the edge right after a write to that address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| adv_ld_i | input | 1 | 1 = advance burst, 0 = load new address |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| cs0_ni | input | 1 | Chip select, active low |
| cs1_ni | input | 1 | Chip select, active low |
| cs_i | input | 1 | Chip select, active high |
| addr_i | input | $clog2(DEPTH) | Word address |
| bw_ni | input | DW/8 | Byte write enables, active low |
| oe_ni | input | 1 | Output enable, active low |
| data_i | input | DW | Write data from the bus |
| data_o | output | DW | Read data to the bus |
| data_oe_o | output | 1 | Bus drive enable |

## Verification
The bench targets the frozen-clock cases. It stalls in the middle of a pending read, and again in the middle of a pending write while garbage sits on `data_i`. A design that captured data on an ignored edge would store the garbage, and one that released the bus would drop the held word. It tries each of the seven non-selecting chip-select combinations, deselects right after a write, and reads back an address on the edge after writing it. A design with wrong select decoding, a dropped pending write or a stale array read would return the wrong word. Bursts that start at offsets 2 and 3 check the four-word wrap: a plain increment would cross into the next block.

// File: rtl/ft_sram_pkg.sv
package ft_sram_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned LANE_W  = 8;
  localparam int unsigned BURST_W = 2;

  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_kind_e;

  function automatic logic [BURST_W-1:0] burst_next(input logic [BURST_W-1:0] ofs);
    return ofs + 1'b1;
  endfunction
endpackage

// File: rtl/ft_sram_ctrl.sv
module ft_sram_ctrl
  import ft_sram_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  logic          adv_ld_i,
  input  logic          rd_wr_i,
  input  logic          sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] bw_ni,
  output logic          vld_o,
  output op_kind_e      kind_o,
  output logic [AW-1:0] addr_o,
  output logic [NB-1:0] bw_no
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [AW-1:0] adv_addr;

  // wrap inside aligned burst block
  assign adv_addr = {addr_o[AW-1:BURST_W], burst_next(addr_o[BURST_W-1:0])};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      kind_o <= OP_RD;
      addr_o <= '0;
      bw_no  <= '1;
    end else if (!cke_ni) begin
      if (adv_ld_i) begin
        addr_o <= adv_addr;
        bw_no  <= bw_ni;
      end else begin
        vld_o <= sel_i;
        if (sel_i) begin
          kind_o <= rd_wr_i ? OP_RD : OP_WR;
          addr_o <= addr_i;
          bw_no  <= bw_ni;
        end
      end
    end
  end
endmodule

// File: rtl/ft_sram_array.sv
module ft_sram_array
  import ft_sram_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned NB   = DW / LANE_W
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [NB-1:0] bw_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  timeunit 1ns;
  timeprecision 1ps;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && !bw_ni[g]) lane_mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = lane_mem[raddr_i];
  end
endmodule

// File: rtl/ft_sram.sv
module ft_sram
  import ft_sram_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned NB   = DW / LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  logic          adv_ld_i,
  input  logic          rd_wr_i,
  input  logic          cs0_ni,
  input  logic          cs1_ni,
  input  logic          cs_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] bw_ni,
  input  logic          oe_ni,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic          sel;
  logic          op_vld;
  op_kind_e      op_kind;
  logic [AW-1:0] op_addr;
  logic [NB-1:0] op_bw_n;
  logic          wr_commit;
  logic [DW-1:0] rdata;

  assign sel = !cs0_ni && !cs1_ni && cs_i;

  ft_sram_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cke_ni   (cke_ni),
    .adv_ld_i (adv_ld_i),
    .rd_wr_i  (rd_wr_i),
    .sel_i    (sel),
    .addr_i   (addr_i),
    .bw_ni    (bw_ni),
    .vld_o    (op_vld),
    .kind_o   (op_kind),
    .addr_o   (op_addr),
    .bw_no    (op_bw_n)
  );

  // late write: data lands on the next active edge
  assign wr_commit = !cke_ni && op_vld && (op_kind == OP_WR);

  ft_sram_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .we_i    (wr_commit),
    .waddr_i (op_addr),
    .bw_ni   (op_bw_n),
    .wdata_i (data_i),
    .raddr_i (op_addr),
    .rdata_o (rdata)
  );

  assign data_oe_o = op_vld && (op_kind == OP_RD) && !oe_ni;
  assign data_o    = data_oe_o ? rdata : '0;
endmodule

// File: rtl/ft_sram_chk.sv
module ft_sram_chk #(
  parameter int unsigned AW = 6,
  parameter int unsigned NB = 4,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cke_ni,
  input logic          adv_ld_i,
  input logic          rd_wr_i,
  input logic          cs0_ni,
  input logic          cs1_ni,
  input logic          cs_i,
  input logic [AW-1:0] addr_i,
  input logic [NB-1:0] bw_ni,
  input logic          oe_ni,
  input logic [DW-1:0] data_i,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic chip_on;
  assign chip_on = (cs0_ni == 1'b0) && (cs1_ni == 1'b0) && (cs_i == 1'b1);

  a_r2_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i && chip_on && rd_wr_i && !oe_ni) |=> (oe_ni || data_oe_o));

  a_r3_write_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i && chip_on && !rd_wr_i) |=> !data_oe_o);

  a_r5_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i && !chip_on) |=> !data_oe_o);

  a_r7_oe_gates_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!data_oe_o && data_o == '0));

  a_r4_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cke_ni) && !oe_ni && !$past(oe_ni)) |-> ($stable(data_o) && $stable(data_oe_o)));
endmodule

bind ft_sram ft_sram_chk #(.AW(AW), .NB(NB), .DW(DW)) u_chk (.*);

// File: tb/sim_ft_sram.sv
module sim_ft_sram;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 64;
  localparam int DW    = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int NB    = DW / 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cke_ni = 1'b0;
  logic          adv_ld_i = 1'b0;
  logic          rd_wr_i = 1'b1;
  logic          cs0_ni = 1'b1;
  logic          cs1_ni = 1'b1;
  logic          cs_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [NB-1:0] bw_ni = '1;
  logic          oe_ni = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;

  always #4 clk_i = ~clk_i;

  ft_sram #(.DEPTH(DEPTH), .DW(DW)) u0 (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // reference model state
  logic [DW-1:0] m [DEPTH];
  bit            p_vld = 0;
  bit            p_wr  = 0;
  int            p_addr = 0;
  logic [NB-1:0] p_bw = '1;

  function automatic logic [DW-1:0] pat(input int i, input int salt);
    return {8'(i), 8'(~i), 8'(i + salt), 8'(8'h5A ^ salt)};
  endfunction

  task automatic check(input string tag, input logic exp_oe, input logic [DW-1:0] exp_d);
    n_chk++;
    if (data_oe_o !== exp_oe || data_o !== exp_d) begin
      n_err++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", tag, data_oe_o, data_o, exp_oe, exp_d);
    end
  endtask

  // one clock: drive at negedge, model updates after posedge, compare at next negedge
  task automatic step(input string tag, input bit cke_n, input bit adv, input bit rw,
                      input logic [2:0] cs, input int a, input logic [NB-1:0] bw,
                      input bit oe_n, input logic [DW-1:0] din);
    bit sel;
    logic [DW-1:0] ed;
    bit eo;
    cke_ni = cke_n; adv_ld_i = adv; rd_wr_i = rw;
    {cs0_ni, cs1_ni, cs_i} = cs;
    addr_i = AW'(a); bw_ni = bw; oe_ni = oe_n; data_i = din;
    @(posedge clk_i);
    #1;
    sel = (cs == 3'b001);
    if (!cke_n) begin
      if (p_vld && p_wr)
        for (int l = 0; l < NB; l++)
          if (!p_bw[l]) m[p_addr][l*8 +: 8] = din[l*8 +: 8];
      if (adv) begin
        p_addr = (p_addr & ~3) | ((p_addr + 1) & 3);
        p_bw = bw;
      end else begin
        p_vld = sel;
        if (sel) begin p_wr = !rw; p_addr = a; p_bw = bw; end
      end
    end
    @(negedge clk_i);
    eo = p_vld && !p_wr && !oe_ni;
    ed = eo ? m[p_addr] : '0;
    check(tag, eo, ed);
  endtask

  localparam logic [2:0] SEL = 3'b001;
  localparam logic [2:0] OFF = 3'b110;

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (data_oe_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1: oe=%0b expected 0 in reset", data_oe_o);
    end
    rst_ni = 1'b1;
    step("R1", 0, 0, 1, OFF, 0, '1, 0, '0);

    // R3/R8: fill array with back-to-back writes
    step("R3", 0, 0, 0, SEL, 0, '0, 0, '0);
    for (int i = 1; i < DEPTH; i++) step("R3", 0, 0, 0, SEL, i, '0, 0, pat(i - 1, 0));
    step("R6", 0, 0, 1, OFF, 0, '1, 0, pat(DEPTH - 1, 0));

    // R2: streaming reads
    for (int i = 0; i < 16; i++) step("R2", 0, 0, 1, SEL, i * 3 % DEPTH, '1, 0, '0);

    // R3: partial byte writes (bw_ni bit low = lane written)
    step("R3", 0, 0, 0, SEL, 5, 4'b1010, 0, '0);
    step("R3", 0, 0, 0, SEL, 9, 4'b0110, 0, 32'h11223344);
    step("R3", 0, 0, 1, SEL, 5, '1, 0, 32'hAABBCCDD);
    step("R3", 0, 0, 1, SEL, 9, '1, 0, '0);

    // R4: freeze during a pending read, inputs toggling
    step("R4", 0, 0, 1, SEL, 12, '1, 0, '0);
    for (int k = 0; k < 3; k++) step("R4", 1, k[0], 0, 3'b000, 33 + k, '0, 0, 32'hDEAD0000 + k);
    step("R4", 0, 0, 1, SEL, 13, '1, 0, '0);

    // R4/R10: freeze during a pending write, garbage on data_i, then read same address
    step("R4", 0, 0, 0, SEL, 20, '0, 0, '0);
    step("R4", 1, 0, 1, SEL, 21, '1, 0, 32'hBAD0BAD0);
    step("R4", 1, 1, 1, SEL, 22, '1, 0, 32'hBAD1BAD1);
    step("R10", 0, 0, 1, SEL, 20, '1, 0, 32'hC0FFEE01);
    step("R10", 0, 0, 1, OFF, 0, '1, 0, '0);

    // R5: every non-selecting combination of chip selects on a read load
    for (int c = 0; c < 8; c++) begin
      if (c[2:0] != 3'b001) begin
        step("R5", 0, 0, 1, SEL, 7, '1, 0, '0);
        step("R5", 0, 0, 1, 3'(c), 8, '1, 0, '0);
        step("R5", 0, 0, 1, 3'(c), 9, '1, 0, '0);
      end
    end

    // R6: deselect right after write still commits the write
    step("R6", 0, 0, 0, SEL, 30, '0, 0, '0);
    step("R6", 0, 0, 1, OFF, 0, '1, 0, 32'h600D600D);
    step("R6", 0, 0, 1, SEL, 30, '1, 0, '0);
    step("R6", 0, 0, 1, OFF, 0, '1, 0, '0);

    // R7: output enable high blocks the bus
    step("R7", 0, 0, 1, SEL, 3, '1, 1, '0);
    step("R7", 0, 0, 1, SEL, 4, '1, 1, '0);
    step("R7", 0, 0, 1, OFF, 0, '1, 0, '0);

    // R8/R10: alternating write and read on the same and different addresses
    for (int i = 0; i < 8; i++) begin
      step("R8", 0, 0, 0, SEL, 40 + i, '0, 0, '0);
      step("R10", 0, 0, 1, SEL, 40 + i, '1, 0, pat(i, 7));
    end

    // R9: read burst starting at offset 2 wraps inside block
    step("R9", 0, 0, 1, SEL, 6, '1, 0, '0);
    for (int k = 0; k < 4; k++) step("R9", 0, 1, 0, OFF, 0, '1, 0, '0);
    // R9: write burst starting at offset 3
    step("R9", 0, 0, 0, SEL, 51, 4'b0000, 0, '0);
    for (int k = 0; k < 3; k++) step("R9", 0, 1, 1, OFF, 0, 4'b0000, 0, pat(k, 9));
    step("R9", 0, 0, 1, SEL, 48, '1, 0, pat(3, 9));
    for (int k = 0; k < 3; k++) step("R9", 0, 1, 0, OFF, 0, '1, 0, '0);
    // R9: advance after deselect stays deselected
    step("R9", 0, 0, 1, OFF, 0, '1, 0, '0);
    step("R9", 0, 1, 1, SEL, 0, '1, 0, '0);

    // random traffic covering R2, R3, R4, R5, R8, R9
    for (int i = 0; i < 600; i++) begin
      logic [2:0] cs;
      cs = ($urandom % 4 != 0) ? SEL : 3'($urandom);
      step("R8", ($urandom % 5 == 0), ($urandom % 4 == 0), $urandom % 2, cs,
           $urandom % DEPTH, NB'($urandom), ($urandom % 8 == 0), $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule